// File: doc/BRIEF.md
# Next Program Counter Unit

This unit decides which instruction a 32-bit load/store core fetches next and keeps the program counter in a register. Each cycle the decoder presents a three-bit flow kind with the two register operands and the two immediate fields of the instruction at the current PC. The unit picks one of five destinations: the straight-line successor, a PC-relative branch target, a region-relative absolute jump, the same jump with a return address recorded, or an address taken from a register. A stall input freezes the counter for as long as the front end is blocked.

For calls the unit drives the return address, the destination register index and a write strobe toward the register file. A flag reports a register-sourced target that does not sit on an instruction boundary. With the default configuration such a target is still followed, with its two low bits cleared.

Top module: `npc_unit`

## Requirements
- R1: A synchronous reset held through a rising clock edge sets `pc_q` to `RESET_PC` (0 by default), and this takes priority over stall.
- R2: Flow code 0 (sequential) and the unused codes 6 and 7 advance `pc_q` by 4 at the next edge, with 32-bit wrap-around.
- R3: Flow code 1 (branch-if-equal) loads PC+4 plus the sign-extended 16-bit offset times 4 when `opnd_a` equals `opnd_b`, and PC+4 otherwise.
- R4: Flow code 2 (branch-if-different) loads the same target as R3 when the operands differ, and PC+4 when they match.
- R5: Flow code 3 (jump) loads the value whose bits 31:28 are bits 31:28 of PC+4, whose bits 27:2 are the 26-bit index and whose bits 1:0 are zero.
- R6: Flow code 4 (call) jumps as in R5 and, in the same cycle, raises `link_we` with `link_val` equal to PC+4 and `link_idx` equal to 31.
- R7: Flow code 5 (register jump) loads `opnd_a` with bits 1:0 cleared.
- R8: `misalign` is high exactly while the flow code is 5 and `opnd_a[1:0]` is nonzero.
- R9: While `stall` is high, `pc_q` keeps its value across the edge and `link_we` stays low.
- R10: `pc_next` always shows the value `pc_q` takes at the next edge when reset is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| stall | input | 1 | Holds the PC and blocks the link write |
| flow | input | 3 | Flow kind: 0 seq, 1 branch-equal, 2 branch-different, 3 jump, 4 call, 5 register jump |
| opnd_a | input | 32 | First register operand and register-jump target |
| opnd_b | input | 32 | Second register operand |
| boff | input | 16 | Signed branch offset in instructions |
| jidx | input | 26 | Jump index field |
| pc_q | output | 32 | Current program counter |
| pc_next | output | 32 | Value loaded at the next edge |
| link_val | output | 32 | Return address, PC+4 |
| link_idx | output | 5 | Destination register of the return address |
| link_we | output | 1 | Write strobe for the return address |
| misalign | output | 1 | Register-jump target not a multiple of 4 |

## Verification
The bench aims at negative offsets that cross zero and wrap around. A design that zero-extended the offset would land far ahead of the PC instead. Jumps are taken from a PC whose upper four bits are nonzero and from a PC ending just below a 256 MB boundary, where PC+4 itself carries into those bits. A unit that took the region bits from the unincremented PC would stay in the old region. Stalled calls check that the strobe is held back, so a register file would not be written twice. Misaligned and aligned register targets check that the flag only follows the low bits during a register jump.

// File: rtl/npc_pkg.sv
package npc_pkg;

    typedef enum logic [2:0] {
        FLOW_SEQ  = 3'd0,
        FLOW_BEQ  = 3'd1,
        FLOW_BNE  = 3'd2,
        FLOW_JMP  = 3'd3,
        FLOW_CALL = 3'd4,
        FLOW_JREG = 3'd5,
        FLOW_RSV6 = 3'd6,
        FLOW_RSV7 = 3'd7
    } flow_e;

    localparam int unsigned INSN_SHIFT = 2;

endpackage

// File: rtl/npc_targets.sv
module npc_targets
    import npc_pkg::*;
#(
    parameter int unsigned XLEN          = 32,
    parameter int unsigned BOFF_W        = 16,
    parameter int unsigned JIDX_W        = 26,
    parameter bit          JR_FORCE_ALIGN = 1'b1
) (
    input  logic [XLEN-1:0]   pc,
    input  logic [BOFF_W-1:0] boff,
    input  logic [JIDX_W-1:0] jidx,
    input  logic [XLEN-1:0]   ra,
    output logic [XLEN-1:0]   seq_pc,
    output logic [XLEN-1:0]   br_pc,
    output logic [XLEN-1:0]   jmp_pc,
    output logic [XLEN-1:0]   reg_pc,
    output logic              reg_mis
);
    localparam int unsigned EXT_W = XLEN - BOFF_W - INSN_SHIFT;
    localparam int unsigned HI_W  = XLEN - JIDX_W - INSN_SHIFT;

    logic [XLEN-1:0] boff_bytes;

    always_comb begin
        seq_pc     = pc + XLEN'(4);
        boff_bytes = {{EXT_W{boff[BOFF_W-1]}}, boff, {INSN_SHIFT{1'b0}}};
        br_pc      = seq_pc + boff_bytes;
        jmp_pc     = {seq_pc[XLEN-1 -: HI_W], jidx, {INSN_SHIFT{1'b0}}};
        reg_mis    = |ra[INSN_SHIFT-1:0];
    end

    generate
        if (JR_FORCE_ALIGN) begin : g_align
            assign reg_pc = {ra[XLEN-1:INSN_SHIFT], {INSN_SHIFT{1'b0}}};
        end else begin : g_raw
            assign reg_pc = ra;
        end
    endgenerate

endmodule

// File: rtl/npc_cond.sv
module npc_cond
    import npc_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  flow_e           flow,
    output logic            take
);
    logic same;

    always_comb begin
        same = (a == b);
        unique case (flow)
            FLOW_BEQ: take = same;
            FLOW_BNE: take = !same;
            default:  take = 1'b0;
        endcase
    end

endmodule

// File: rtl/npc_unit.sv
module npc_unit
    import npc_pkg::*;
#(
    parameter int unsigned XLEN          = 32,
    parameter int unsigned BOFF_W        = 16,
    parameter int unsigned JIDX_W        = 26,
    parameter int unsigned REG_IDX_W     = 5,
    parameter int unsigned LINK_REG      = 31,
    parameter logic [31:0] RESET_PC      = 32'h0,
    parameter bit          JR_FORCE_ALIGN = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 stall,
    input  logic [2:0]           flow,
    input  logic [XLEN-1:0]      opnd_a,
    input  logic [XLEN-1:0]      opnd_b,
    input  logic [BOFF_W-1:0]    boff,
    input  logic [JIDX_W-1:0]    jidx,
    output logic [XLEN-1:0]      pc_q,
    output logic [XLEN-1:0]      pc_next,
    output logic [XLEN-1:0]      link_val,
    output logic [REG_IDX_W-1:0] link_idx,
    output logic                 link_we,
    output logic                 misalign
);
    typedef struct packed {
        logic [XLEN-1:0] pc;
    } state_t;

    state_t st_d, st_q;
    flow_e  kind;

    logic [XLEN-1:0] seq_pc, br_pc, jmp_pc, reg_pc;
    logic            reg_mis, take;

    assign kind = flow_e'(flow);

    npc_targets #(
        .XLEN(XLEN), .BOFF_W(BOFF_W), .JIDX_W(JIDX_W), .JR_FORCE_ALIGN(JR_FORCE_ALIGN)
    ) u_tgt (
        .pc(st_q.pc), .boff(boff), .jidx(jidx), .ra(opnd_a),
        .seq_pc(seq_pc), .br_pc(br_pc), .jmp_pc(jmp_pc),
        .reg_pc(reg_pc), .reg_mis(reg_mis)
    );

    npc_cond #(.XLEN(XLEN)) u_cond (
        .a(opnd_a), .b(opnd_b), .flow(kind), .take(take)
    );

    always_comb begin
        st_d     = st_q;
        link_we  = 1'b0;
        misalign = 1'b0;
        if (!stall) begin
            unique case (kind)
                FLOW_BEQ, FLOW_BNE: st_d.pc = take ? br_pc : seq_pc;
                FLOW_JMP:           st_d.pc = jmp_pc;
                FLOW_CALL: begin
                    st_d.pc = jmp_pc;
                    link_we = 1'b1;
                end
                FLOW_JREG:          st_d.pc = reg_pc;
                default:            st_d.pc = seq_pc;
            endcase
        end
        if (kind == FLOW_JREG) misalign = reg_mis;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '{pc: XLEN'(RESET_PC)};
        else     st_q <= st_d;
    end

    assign pc_q     = st_q.pc;
    assign pc_next  = st_d.pc;
    assign link_val = seq_pc;
    assign link_idx = REG_IDX_W'(LINK_REG);

endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk #(
    parameter int unsigned XLEN = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            stall,
    input logic [2:0]      flow,
    input logic [XLEN-1:0] opnd_a,
    input logic [XLEN-1:0] pc_q,
    input logic [XLEN-1:0] pc_next,
    input logic [XLEN-1:0] link_val,
    input logic            link_we,
    input logic            misalign
);
    logic [XLEN-1:0] pc_plus4;
    assign pc_plus4 = pc_q + XLEN'(4);

    a_r1_reset_zero: assert property (@(posedge clk) rst |=> pc_q == '0);

    a_r2_seq_step: assert property (@(posedge clk) disable iff (rst)
        (!stall && flow == 3'd0) |=> pc_q == $past(pc_plus4));

    a_r5_jump_region: assert property (@(posedge clk) disable iff (rst)
        (!stall && flow == 3'd3) |=> pc_q[XLEN-1 -: 4] == $past(pc_plus4[XLEN-1 -: 4]));

    a_r6_link_addr: assert property (@(posedge clk) disable iff (rst)
        link_we |-> (link_val == pc_plus4 && flow == 3'd4));

    a_r7_jreg_aligned: assert property (@(posedge clk) disable iff (rst)
        (!stall && flow == 3'd5) |=> pc_q[1:0] == 2'b00);

    a_r8_flag_only_jreg: assert property (@(posedge clk) disable iff (rst)
        misalign |-> (flow == 3'd5 && opnd_a[1:0] != 2'b00));

    a_r9_stall_hold: assert property (@(posedge clk) disable iff (rst)
        stall |=> $stable(pc_q));

    a_r9_stall_no_link: assert property (@(posedge clk) disable iff (rst)
        stall |-> !link_we);

    a_r10_next_matches: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> pc_q == $past(pc_next));

endmodule

bind npc_unit npc_unit_chk #(.XLEN(XLEN)) u_chk (
    .clk(clk), .rst(rst), .stall(stall), .flow(flow), .opnd_a(opnd_a),
    .pc_q(pc_q), .pc_next(pc_next), .link_val(link_val),
    .link_we(link_we), .misalign(misalign)
);

// File: tb/sim_npc_unit.sv
module sim_npc_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        stall = 1'b0;
    logic [2:0]  flow = 3'd0;
    logic [31:0] opnd_a = '0, opnd_b = '0;
    logic [15:0] boff = '0;
    logic [25:0] jidx = '0;
    logic [31:0] pc_q, pc_next, link_val;
    logic [4:0]  link_idx;
    logic        link_we, misalign;

    int checks = 0;
    int errors = 0;
    logic [31:0] model_pc = '0;

    always #10 clk = ~clk;

    npc_unit u0 (
        .clk(clk), .rst(rst), .stall(stall), .flow(flow),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .boff(boff), .jidx(jidx),
        .pc_q(pc_q), .pc_next(pc_next), .link_val(link_val),
        .link_idx(link_idx), .link_we(link_we), .misalign(misalign)
    );

    task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] model_next(input logic [2:0] c, input logic [31:0] a, input logic [31:0] b,
                                              input logic [15:0] im, input logic [25:0] jx, input logic st);
        logic [31:0] p4;
        integer offs;
        p4   = model_pc + 32'd4;
        offs = $signed(im);
        if (st) return model_pc;
        case (c)
            3'd1:    return (a == b) ? p4 + 32'(offs * 4) : p4;
            3'd2:    return (a != b) ? p4 + 32'(offs * 4) : p4;
            3'd3,
            3'd4:    return (p4 & 32'hF000_0000) + 32'(jx) * 32'd4;
            3'd5:    return a - (a % 32'd4);
            default: return p4;
        endcase
    endfunction

    // Starts and ends at a falling edge.
    task automatic step(input logic [2:0] c, input logic [31:0] a, input logic [31:0] b,
                        input logic [15:0] im, input logic [25:0] jx, input logic st, input string req);
        logic [31:0] exp;
        flow = c; opnd_a = a; opnd_b = b; boff = im; jidx = jx; stall = st;
        #1;
        exp = model_next(c, a, b, im, jx, st);
        check(pc_next == exp, {req, " pc_next"}, pc_next, exp);
        check(link_we == (c == 3'd4 && !st), {req, " link_we"}, 32'(link_we), 32'(c == 3'd4 && !st));
        if (c == 3'd4 && !st) begin
            check(link_val == model_pc + 32'd4, "R6 link_val", link_val, model_pc + 32'd4);
            check(link_idx == 5'd31, "R6 link_idx", 32'(link_idx), 32'd31);
        end
        check(misalign == (c == 3'd5 && a[1:0] != 2'b00), "R8 misalign", 32'(misalign),
              32'(c == 3'd5 && a[1:0] != 2'b00));
        @(posedge clk);
        @(negedge clk);
        model_pc = exp;
        check(pc_q == model_pc, {req, " pc_q"}, pc_q, model_pc);
    endtask

    task automatic do_reset(input logic st);
        rst = 1'b1; stall = st; flow = 3'd0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        check(pc_q == 32'd0, "R1 reset", pc_q, 32'd0);
        rst = 1'b0; stall = 1'b0;
        model_pc = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        do_reset(1'b0);
        // R2 sequential and unused codes
        step(3'd0, 0, 0, 0, 0, 0, "R2 seq");
        step(3'd6, 0, 0, 0, 0, 0, "R2 code6");
        step(3'd7, 0, 0, 0, 0, 0, "R2 code7");
        // R3 branch-equal taken / not taken
        step(3'd1, 32'h55, 32'h55, 16'd5, 0, 0, "R3 beq taken");
        step(3'd1, 32'h55, 32'h56, 16'd9, 0, 0, "R3 beq not taken");
        // R4 branch-different
        step(3'd2, 32'h7, 32'h7, 16'd9, 0, 0, "R4 bne not taken");
        step(3'd2, 32'h7, 32'h8, 16'hFFFD, 0, 0, "R4 bne backward");
        // negative offset crossing zero with wrap
        step(3'd1, 1, 1, 16'hFFF0, 0, 0, "R3 beq wrap");
        step(3'd2, 1, 2, 16'h8000, 0, 0, "R4 bne max negative");
        // R7 register jump into high region, aligned then misaligned
        step(3'd5, 32'hA000_0100, 0, 0, 0, 0, "R7 jreg aligned");
        step(3'd5, 32'hA000_2003, 0, 0, 0, 0, "R7 jreg misaligned");
        // R5 jump keeps region of PC+4
        step(3'd3, 0, 0, 0, 26'h123_4567, 0, "R5 jump");
        // PC just below a region boundary: PC+4 carries into the top bits
        step(3'd5, 32'h2FFF_FFFC, 0, 0, 0, 0, "R7 jreg boundary");
        step(3'd3, 0, 0, 0, 26'h000_0010, 0, "R5 jump carry region");
        // R6 call
        step(3'd4, 0, 0, 0, 26'h3FF_FFFF, 0, "R6 call");
        // R9 stall during call and branch
        step(3'd4, 0, 0, 0, 26'h000_0001, 1, "R9 stall call");
        step(3'd1, 3, 3, 16'd4, 0, 1, "R9 stall branch");
        step(3'd5, 32'h0000_0002, 0, 0, 0, 1, "R9 stall jreg");
        step(3'd4, 0, 0, 0, 26'h000_0002, 0, "R6 call after stall");
        // R1 reset wins over stall
        do_reset(1'b1);
        step(3'd0, 0, 0, 0, 0, 0, "R2 after reset");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule